// File: doc/BRIEF.md
# Split-Mode Tagged Translation Buffer

This block caches virtual-to-physical page translations for a word-addressed processor. Translations for executive mode and for user mode live in two separate tables. Each table is two-way set associative with 512 sets. A lookup presents a mode, a process context number and a 21-bit virtual page. One cycle later the block returns a hit flag and an 18-bit physical page. Pages are 512 words and physical addresses are 27 bits. The low nine address bits bypass the block.

User entries are tagged with the context number that filled them, so switching processes needs no invalidation. After a miss, the requester installs a translation through the fill port. When the state of one physical page changes, a sweep command removes every entry mapping that page from both tables. The sweep walks one set per clock and holds the block busy for 512 cycles. A flush input clears both tables in a single cycle.

Top module: `split_xlat_buf`

## Requirements
- R1: A lookup with `lkp_user_i`=1 consults only the user table, and one with 0 consults only the executive table; a translation filled in one mode never hits in the other.
- R2: The set index is the low 9 bits of the virtual page and the upper 12 bits are the tag; two pages that share an index are held together, one per way.
- R3: A user-table hit requires the stored context number to equal `lkp_ctx_i`; executive lookups ignore the context number.
- R4: A lookup accepted on a clock edge (`lkp_valid_i`=1, `busy_o`=0) yields `rsp_valid_o`=1 with `rsp_hit_o` and `rsp_ppn_o` on the following edge; `rsp_hit_o` is never 1 without `rsp_valid_o`.
- R5: A fill goes to way 0 if it is invalid, else to way 1 if it is invalid, else to the least recently used way; every hit and every fill marks the way it touched as most recently used.
- R6: A sweep invalidates every entry in both tables whose physical page equals `sweep_ppn_i` (sampled at start) and leaves all other entries in place, including those at set 511.
- R7: `sweep_start_i` while idle raises `busy_o` on the next edge for exactly 512 cycles; a start pulse while busy is ignored and does not lengthen the sweep.
- R8: While `busy_o`=1, lookups get no response and fills are dropped.
- R9: `flush_i` invalidates every entry of both tables on one edge, and a fill presented on the same edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_user_i | input | 1 | Lookup mode: 1 user, 0 executive |
| lkp_ctx_i | input | 8 | Current process context number |
| lkp_vpn_i | input | 21 | Virtual page to translate |
| rsp_valid_o | output | 1 | Lookup result valid |
| rsp_hit_o | output | 1 | Translation found |
| rsp_ppn_o | output | 18 | Physical page of the hit |
| fill_valid_i | input | 1 | Install a translation |
| fill_user_i | input | 1 | Target table: 1 user, 0 executive |
| fill_ctx_i | input | 8 | Context number stored with a user fill |
| fill_vpn_i | input | 21 | Virtual page of the fill |
| fill_ppn_i | input | 18 | Physical page of the fill |
| sweep_start_i | input | 1 | Start a single-page sweep |
| sweep_ppn_i | input | 18 | Physical page to remove |
| busy_o | output | 1 | Sweep in progress |
| flush_i | input | 1 | Invalidate both tables |

## Verification
A lookup result is due on the edge after the edge that accepts the request. The bench drives inputs on the falling edge and reads `rsp_valid_o`, `rsp_hit_o` and `rsp_ppn_o` on the next falling edge. A fill or a flush acts on the rising edge that follows the falling edge on which it was driven, so the next lookup already sees the new state. `busy_o` rises one edge after the start pulse, and the bench counts the falling edges on which it stays high, expecting exactly 512. Checks after a sweep are made only once `busy_o` has dropped.

// File: rtl/xlat_buf_pkg.sv
package xlat_buf_pkg;
  localparam int unsigned DEF_VPN_W = 21;
  localparam int unsigned DEF_PPN_W = 18;
  localparam int unsigned DEF_CTX_W = 8;
  localparam int unsigned DEF_IDX_W = 9;

  // prefer invalid ways in order, then the LRU pointer
  function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
    if (!vld[0])      return 1'b0;
    else if (!vld[1]) return 1'b1;
    else              return lru;
  endfunction
endpackage

// File: rtl/xlat_buf_table.sv
module xlat_buf_table
  import xlat_buf_pkg::*;
#(
  parameter int unsigned VPN_W   = DEF_VPN_W,
  parameter int unsigned PPN_W   = DEF_PPN_W,
  parameter int unsigned CTX_W   = DEF_CTX_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter bit          USE_CTX = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_en_i,
  input  logic [CTX_W-1:0] lkp_ctx_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             fill_en_i,
  input  logic [CTX_W-1:0] fill_ctx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             flush_i,
  input  logic             swp_en_i,
  input  logic [IDX_W-1:0] swp_idx_i,
  input  logic [PPN_W-1:0] swp_ppn_i
);
  localparam int unsigned SETS  = 1 << IDX_W;
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  logic [TAG_W-1:0] tag_q [SETS][2];
  logic [CTX_W-1:0] ctx_q [SETS][2];
  logic [PPN_W-1:0] pfn_q [SETS][2];
  logic [1:0]       vld_q [SETS];
  logic             lru_q [SETS];

  logic [IDX_W-1:0] l_idx, f_idx;
  logic [TAG_W-1:0] l_tag, f_tag;
  logic [1:0]       way_hit, swp_kill;
  logic             hit_way, fill_way, fill_we;

  assign l_idx = lkp_vpn_i[IDX_W-1:0];
  assign l_tag = lkp_vpn_i[VPN_W-1:IDX_W];
  assign f_idx = fill_vpn_i[IDX_W-1:0];
  assign f_tag = fill_vpn_i[VPN_W-1:IDX_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign way_hit[w]  = vld_q[l_idx][w] && (tag_q[l_idx][w] == l_tag) &&
                         (!USE_CTX || (ctx_q[l_idx][w] == lkp_ctx_i));
    assign swp_kill[w] = swp_en_i && vld_q[swp_idx_i][w] &&
                         (pfn_q[swp_idx_i][w] == swp_ppn_i);
  end

  assign hit_way  = way_hit[1];
  assign fill_we  = fill_en_i && !flush_i;
  assign fill_way = pick_victim(vld_q[f_idx], lru_q[f_idx]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o <= 1'b0;
      ppn_o <= '0;
    end else if (lkp_en_i) begin
      hit_o <= |way_hit;
      ppn_o <= pfn_q[l_idx][hit_way];
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_we) begin
      tag_q[f_idx][fill_way] <= f_tag;
      ctx_q[f_idx][fill_way] <= fill_ctx_i;
      pfn_q[f_idx][fill_way] <= fill_ppn_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SETS; i++) begin
        vld_q[i] <= '0;
        lru_q[i] <= 1'b0;
      end
    end else begin
      if (flush_i) begin
        for (int i = 0; i < SETS; i++) vld_q[i] <= '0;
      end else begin
        if (swp_en_i) vld_q[swp_idx_i] <= vld_q[swp_idx_i] & ~swp_kill;
        if (fill_we)  vld_q[f_idx][fill_way] <= 1'b1;
      end
      // lru_q holds the way to evict next
      if (lkp_en_i && |way_hit) lru_q[l_idx] <= ~hit_way;
      if (fill_we)              lru_q[f_idx] <= ~fill_way;
    end
  end
endmodule

// File: rtl/xlat_buf_sweep.sv
module xlat_buf_sweep #(
  parameter int unsigned PPN_W = 18,
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PPN_W-1:0] ppn_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PPN_W-1:0] ppn_o
);
  localparam logic [IDX_W-1:0] LAST = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
      ppn_o  <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o <= 1'b1;
        idx_o  <= '0;
        ppn_o  <= ppn_i;
      end
    end else begin
      idx_o <= idx_o + 1'b1;
      if (idx_o == LAST) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/split_xlat_buf.sv
module split_xlat_buf
  import xlat_buf_pkg::*;
#(
  parameter int unsigned VPN_W = DEF_VPN_W,
  parameter int unsigned PPN_W = DEF_PPN_W,
  parameter int unsigned CTX_W = DEF_CTX_W,
  parameter int unsigned IDX_W = DEF_IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic             lkp_user_i,
  input  logic [CTX_W-1:0] lkp_ctx_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic             rsp_valid_o,
  output logic             rsp_hit_o,
  output logic [PPN_W-1:0] rsp_ppn_o,
  input  logic             fill_valid_i,
  input  logic             fill_user_i,
  input  logic [CTX_W-1:0] fill_ctx_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             sweep_start_i,
  input  logic [PPN_W-1:0] sweep_ppn_i,
  output logic             busy_o,
  input  logic             flush_i
);
  logic             lkp_acc, fill_acc, sel_user_q, rsp_q;
  logic [IDX_W-1:0] swp_idx;
  logic [PPN_W-1:0] swp_ppn;
  logic             tbl_hit [2];
  logic [PPN_W-1:0] tbl_ppn [2];

  assign lkp_acc  = lkp_valid_i && !busy_o;
  assign fill_acc = fill_valid_i && !busy_o;

  xlat_buf_sweep #(.PPN_W(PPN_W), .IDX_W(IDX_W)) i_sweep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(sweep_start_i),
    .ppn_i  (sweep_ppn_i),
    .busy_o (busy_o),
    .idx_o  (swp_idx),
    .ppn_o  (swp_ppn)
  );

  // table 0 executive, table 1 user
  for (genvar t = 0; t < 2; t++) begin : g_tbl
    xlat_buf_table #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .CTX_W(CTX_W), .IDX_W(IDX_W),
      .USE_CTX(t == 1)
    ) i_table (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lkp_en_i  (lkp_acc && (lkp_user_i == 1'(t))),
      .lkp_ctx_i (lkp_ctx_i),
      .lkp_vpn_i (lkp_vpn_i),
      .hit_o     (tbl_hit[t]),
      .ppn_o     (tbl_ppn[t]),
      .fill_en_i (fill_acc && (fill_user_i == 1'(t))),
      .fill_ctx_i(fill_ctx_i),
      .fill_vpn_i(fill_vpn_i),
      .fill_ppn_i(fill_ppn_i),
      .flush_i   (flush_i),
      .swp_en_i  (busy_o),
      .swp_idx_i (swp_idx),
      .swp_ppn_i (swp_ppn)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q      <= 1'b0;
      sel_user_q <= 1'b0;
    end else begin
      rsp_q <= lkp_acc;
      if (lkp_acc) sel_user_q <= lkp_user_i;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign rsp_hit_o   = rsp_q && (sel_user_q ? tbl_hit[1] : tbl_hit[0]);
  assign rsp_ppn_o   = sel_user_q ? tbl_ppn[1] : tbl_ppn[0];
endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk #(
  parameter int unsigned IDX_W = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic lkp_valid_i,
  input logic rsp_valid_o,
  input logic rsp_hit_o,
  input logic sweep_start_i,
  input logic busy_o,
  input logic flush_i
);
  localparam int unsigned SETS = 1 << IDX_W;
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= 0;
    else if (busy_o) busy_cnt <= busy_cnt + 1;
    else             busy_cnt <= 0;
  end

  // R4
  rsp_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(lkp_valid_i && !busy_o));
  // R4
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);
  // R8
  busy_no_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && busy_o) |=> !rsp_valid_o);
  // R7
  sweep_starts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_start_i && !busy_o) |=> busy_o);
  // R7
  sweep_length_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == SETS));
  // R9
  flush_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && !busy_o && $past(flush_i)) |=> !rsp_hit_o);
endmodule

bind split_xlat_buf xlat_buf_chk #(.IDX_W(IDX_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_valid_i  (lkp_valid_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .sweep_start_i(sweep_start_i),
  .busy_o       (busy_o),
  .flush_i      (flush_i)
);

// File: tb/test_split_xlat_buf.sv
module test_split_xlat_buf;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 0, lkp_user_i = 0;
  logic [7:0]  lkp_ctx_i = '0;
  logic [20:0] lkp_vpn_i = '0;
  logic        rsp_valid_o, rsp_hit_o, busy_o;
  logic [17:0] rsp_ppn_o;
  logic        fill_valid_i = 0, fill_user_i = 0;
  logic [7:0]  fill_ctx_i = '0;
  logic [20:0] fill_vpn_i = '0;
  logic [17:0] fill_ppn_i = '0;
  logic        sweep_start_i = 0, flush_i = 0;
  logic [17:0] sweep_ppn_i = '0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  split_xlat_buf i_split_xlat_buf (
    .clk_i(clk), .rst_ni(rst_ni),
    .lkp_valid_i(lkp_valid_i), .lkp_user_i(lkp_user_i), .lkp_ctx_i(lkp_ctx_i),
    .lkp_vpn_i(lkp_vpn_i), .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
    .rsp_ppn_o(rsp_ppn_o), .fill_valid_i(fill_valid_i), .fill_user_i(fill_user_i),
    .fill_ctx_i(fill_ctx_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .sweep_start_i(sweep_start_i), .sweep_ppn_i(sweep_ppn_i), .busy_o(busy_o),
    .flush_i(flush_i)
  );

  function automatic logic [20:0] vp(input int tag, input int idx);
    return {tag[11:0], idx[8:0]};
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fill(input bit user, input int ctx, input logic [20:0] vpn, input int ppn);
    @(negedge clk);
    fill_valid_i = 1; fill_user_i = user; fill_ctx_i = ctx[7:0];
    fill_vpn_i = vpn; fill_ppn_i = ppn[17:0];
    @(negedge clk);
    fill_valid_i = 0;
  endtask

  // drives at a falling edge, result read on the next falling edge
  task automatic lookup(input string req, input bit user, input int ctx,
                        input logic [20:0] vpn, input bit exp_hit, input int exp_ppn);
    @(negedge clk);
    lkp_valid_i = 1; lkp_user_i = user; lkp_ctx_i = ctx[7:0]; lkp_vpn_i = vpn;
    @(negedge clk);
    lkp_valid_i = 0;
    check({req, " rsp_valid"}, rsp_valid_o, 1);
    check({req, " hit"}, rsp_hit_o, exp_hit);
    if (exp_hit) check({req, " ppn"}, rsp_ppn_o, exp_ppn);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1;
    @(negedge clk);
    flush_i = 0;
  endtask

  task automatic t_reset();
    check("R4 reset rsp_valid", rsp_valid_o, 0);
    check("R7 reset busy", busy_o, 0);
    lookup("R1 empty exec", 0, 0, vp(1, 3), 0, 0);
    lookup("R1 empty user", 1, 0, vp(1, 3), 0, 0);
  endtask

  task automatic t_modes();
    fill(0, 0, vp(5, 10), 'h111);
    lookup("R1 exec hit", 0, 0, vp(5, 10), 1, 'h111);
    lookup("R1 exec fill not in user", 1, 0, vp(5, 10), 0, 0);
    fill(1, 7, vp(6, 11), 'h222);
    lookup("R1 user fill not in exec", 0, 7, vp(6, 11), 0, 0);
    lookup("R3 exec ignores ctx", 0, 99, vp(5, 10), 1, 'h111);
    lookup("R3 user ctx match", 1, 7, vp(6, 11), 1, 'h222);
    lookup("R3 user ctx mismatch", 1, 8, vp(6, 11), 0, 0);
    fill(1, 8, vp(6, 11), 'h333);
    lookup("R3 two ctx coexist a", 1, 7, vp(6, 11), 1, 'h222);
    lookup("R3 two ctx coexist b", 1, 8, vp(6, 11), 1, 'h333);
    lookup("R2 tag differs", 0, 0, vp(4, 10), 0, 0);
  endtask

  task automatic t_lru();
    do_flush();
    fill(0, 0, vp(1, 20), 'hA);
    fill(0, 0, vp(2, 20), 'hB);
    lookup("R2 way a", 0, 0, vp(1, 20), 1, 'hA);   // A now MRU
    lookup("R2 way b", 0, 0, vp(2, 20), 1, 'hB);   // B now MRU
    lookup("R5 touch a", 0, 0, vp(1, 20), 1, 'hA); // B now LRU
    fill(0, 0, vp(3, 20), 'hC);
    lookup("R5 a kept", 0, 0, vp(1, 20), 1, 'hA);
    lookup("R5 b evicted", 0, 0, vp(2, 20), 0, 0);
    lookup("R5 c present", 0, 0, vp(3, 20), 1, 'hC);
    fill(0, 0, vp(4, 20), 'hD);                    // A is LRU now
    lookup("R5 a evicted after fill mru", 0, 0, vp(1, 20), 0, 0);
    lookup("R5 c kept", 0, 0, vp(3, 20), 1, 'hC);
  endtask

  task automatic t_sweep();
    int busy_n = 0;
    do_flush();
    fill(0, 0, vp(1, 30), 'h55);
    fill(1, 2, vp(2, 511), 'h55);
    fill(0, 0, vp(3, 30), 'h66);
    fill(1, 2, vp(4, 0), 'h77);
    @(negedge clk);
    sweep_start_i = 1; sweep_ppn_i = 'h55;
    @(negedge clk);
    sweep_start_i = 0; sweep_ppn_i = 'h66;
    check("R7 busy after start", busy_o, 1);
    while (busy_o && busy_n < 2000) begin
      busy_n++;
      if (busy_n == 5) begin
        lkp_valid_i = 1; lkp_user_i = 0; lkp_vpn_i = vp(3, 30);
        fill_valid_i = 1; fill_user_i = 0; fill_vpn_i = vp(9, 40); fill_ppn_i = 'h99;
      end else if (busy_n == 6) begin
        check("R8 no rsp while busy", rsp_valid_o, 0);
        lkp_valid_i = 0; fill_valid_i = 0;
      end else if (busy_n == 100) begin
        sweep_start_i = 1;
      end else if (busy_n == 101) begin
        sweep_start_i = 0;
      end
      @(negedge clk);
    end
    check("R7 busy length", busy_n, 512);
    lookup("R6 exec match removed", 0, 0, vp(1, 30), 0, 0);
    lookup("R6 user match at set 511 removed", 1, 2, vp(2, 511), 0, 0);
    lookup("R6 other page kept", 0, 0, vp(3, 30), 1, 'h66);
    lookup("R6 user other page kept", 1, 2, vp(4, 0), 1, 'h77);
    lookup("R8 fill while busy dropped", 0, 0, vp(9, 40), 0, 0);
  endtask

  task automatic t_flush();
    fill(0, 0, vp(7, 50), 'h12);
    fill(1, 3, vp(7, 51), 'h13);
    lookup("R9 pre flush", 1, 3, vp(7, 51), 1, 'h13);
    @(negedge clk);
    flush_i = 1;
    fill_valid_i = 1; fill_user_i = 0; fill_vpn_i = vp(8, 52); fill_ppn_i = 'h14;
    @(negedge clk);
    flush_i = 0; fill_valid_i = 0;
    lookup("R9 exec cleared", 0, 0, vp(7, 50), 0, 0);
    lookup("R9 user cleared", 1, 3, vp(7, 51), 0, 0);
    lookup("R9 flush beats fill", 0, 0, vp(8, 52), 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    t_reset();
    t_modes();
    t_lru();
    t_sweep();
    t_flush();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule